// File: doc/BRIEF.md
# Endian-Configurable Byte-Addressed Word Memory

This block is a small data memory organised as 32-bit words but addressed by byte. A requester presents a byte address, an access size (byte, halfword or word), a write flag and store data on a single synchronous port. One clock later the block returns load data or an error indication. Word `w` covers byte addresses `4w` to `4w+3`.

A mode input selects how the bytes of a multi-byte value map onto consecutive byte addresses. In little-endian mode the least significant byte sits at the lowest address. In big-endian mode the most significant byte sits there. The stored bytes themselves are fixed by address. Data written in one mode and read in the other therefore shows the byte reversal at the port.

Every request is checked for natural alignment. A misaligned request, or one with the reserved size code, is rejected: it raises an error pulse, changes no stored byte and returns zero data.

Top module: `endian_mem_port`

## Requirements
- R1: After reset every stored byte is zero, and `rvalid_o`, `err_o` and `rdata_o` are low.
- R2: In little-endian mode (`big_endian_i`=0) byte `k` of a word value (bits `8k+7:8k`) is placed at byte address `base+k`. In big-endian mode (`big_endian_i`=1) it is placed at `base+(n-1-k)` for an `n`-byte access. The byte at a given address is the same whichever mode wrote or reads it.
- R3: `size_i` encodes 0 = byte, 1 = halfword, 2 = word, 3 = reserved. A byte access is always aligned. A halfword access needs `addr_i[0]`=0. A word access needs `addr_i[1:0]`=00. Size 3 is always rejected.
- R4: A rejected request raises `err_o` in the cycle after it is accepted, for that one cycle only.
- R5: A rejected store changes no stored byte.
- R6: `rdata_o` is zero in every cycle except the response cycle of an accepted, aligned load, so a rejected load returns zero.
- R7: Byte and halfword loads return their value zero-extended and right-justified in `rdata_o`.
- R8: A byte or halfword store writes only the addressed bytes, and the other bytes of the word keep their values.
- R9: `rvalid_o` is high exactly in the cycle after a load request. Data stored by a request is returned by a load issued in the very next cycle.
- R10: The endian mode is captured only at clock edges where `req_i` is low. A request uses the mode captured at the last such edge, and changes of `big_endian_i` while `req_i` is high have no effect.
- R11: A cycle with no request is followed by a cycle with `rvalid_o` and `err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| big_endian_i | input | 1 | Endian mode: 1 = big, 0 = little; captured while idle |
| req_i | input | 1 | Request valid this cycle |
| we_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | Access size code |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Store value, right-justified |
| rdata_o | output | DATA_W | Load value, right-justified, zero-extended |
| rvalid_o | output | 1 | Load response cycle |
| err_o | output | 1 | Rejected-request pulse |

## Verification
Some behaviour is checked by properties on every cycle:
- the alignment decision per size code, and the single-cycle error pulse;
- the response timing of loads versus stores, and the quiet outputs after idle cycles;
- zero data outside good load responses, zero extension of narrow loads, and the freeze of the captured mode while requests are active.

Other behaviour needs the bench's byte-level model of the memory:
- the actual byte placement in each mode and across mode changes;
- that narrow stores leave neighbouring bytes intact;
- that rejected stores leave memory untouched;
- that a load right after a store sees the new data.

// File: rtl/emp_pkg.sv
package emp_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  function automatic int size_bytes(acc_size_e s, int nb);
    case (s)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      SZ_WORD: return nb;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/emp_align_chk.sv
module emp_align_chk
  import emp_pkg::*;
#(
  parameter int unsigned OFF_W = 2
) (
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             misalign_o
);
  always_comb begin
    case (size_i)
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = off_i[0];
      SZ_WORD: misalign_o = |off_i;
      default: misalign_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/emp_lane_pack.sv
// Maps a right-justified store value onto fixed byte lanes (lane = address offset).
module emp_lane_pack
  import emp_pkg::*;
#(
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned NB     = DATA_W / 8,
  localparam int unsigned OFF_W  = $clog2(NB)
) (
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             big_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] lanes_o,
  output logic [NB-1:0]    be_o
);
  int                n;
  logic [DATA_W-1:0] val;

  always_comb begin
    n   = size_bytes(size_i, NB);
    val = '0;
    for (int i = 0; i < NB; i++) begin
      if (i < n) begin
        if (big_i) val[8*i+:8] = data_i[8*(n-1-i)+:8];
        else       val[8*i+:8] = data_i[8*i+:8];
      end
    end
    lanes_o = val << {off_i, 3'b000};
    for (int i = 0; i < NB; i++) begin
      be_o[i] = (i >= int'(off_i)) && (i < int'(off_i) + n);
    end
  end
endmodule

// File: rtl/emp_lane_unpack.sv
// Extracts a right-justified, zero-extended load value from a stored word.
module emp_lane_unpack
  import emp_pkg::*;
#(
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned NB     = DATA_W / 8,
  localparam int unsigned OFF_W  = $clog2(NB)
) (
  input  acc_size_e         size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              big_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o
);
  int                n;
  logic [DATA_W-1:0] sh;

  always_comb begin
    n      = size_bytes(size_i, NB);
    sh     = word_i >> {off_i, 3'b000};
    data_o = '0;
    for (int i = 0; i < NB; i++) begin
      if (i < n) begin
        if (big_i) data_o[8*i+:8] = sh[8*(n-1-i)+:8];
        else       data_o[8*i+:8] = sh[8*i+:8];
      end
    end
  end
endmodule

// File: rtl/emp_word_store.sv
module emp_word_store #(
  parameter  int unsigned DATA_W = 32,
  parameter  int unsigned DEPTH  = 16,
  localparam int unsigned NB     = DATA_W / 8,
  localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [NB-1:0]     be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] cell_q [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < DEPTH; w++) cell_q[w] <= '0;
      end else if (wr_i && be_i[b]) begin
        cell_q[idx_i] <= wdata_i[8*b+:8];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rd_q <= '0;
      else if (rd_i) rd_q <= cell_q[idx_i];
    end

    assign rdata_o[8*b+:8] = rd_q;
  end
endmodule

// File: rtl/endian_mem_port.sv
module endian_mem_port
  import emp_pkg::*;
#(
  parameter  int unsigned ADDR_W = 6,
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned NB     = DATA_W / 8,
  localparam int unsigned OFF_W  = $clog2(NB),
  localparam int unsigned IDX_W  = ADDR_W - OFF_W,
  localparam int unsigned DEPTH  = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              big_endian_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              err_o
);
  acc_size_e         size;
  logic [OFF_W-1:0]  off;
  logic [IDX_W-1:0]  idx;
  logic              misalign, wr_en, rd_en;
  logic              mode_q;
  logic [NB-1:0]     be;
  logic [DATA_W-1:0] lanes, word_rd, ld_val;

  logic              ld_q, err_q, ok_ld_q, mode_rsp_q;
  acc_size_e         size_q;
  logic [OFF_W-1:0]  off_q;

  assign size = acc_size_e'(size_i);
  assign off  = addr_i[OFF_W-1:0];
  assign idx  = addr_i[ADDR_W-1:OFF_W];

  // mode only follows the pin between requests
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= 1'b0;
    else if (!req_i) mode_q <= big_endian_i;
  end

  emp_align_chk #(.OFF_W(OFF_W)) i_align (
    .size_i    (size),
    .off_i     (off),
    .misalign_o(misalign)
  );

  assign wr_en = req_i && !misalign && we_i;
  assign rd_en = req_i && !misalign && !we_i;

  emp_lane_pack #(.DATA_W(DATA_W)) i_pack (
    .size_i (size),
    .off_i  (off),
    .big_i  (mode_q),
    .data_i (wdata_i),
    .lanes_o(lanes),
    .be_o   (be)
  );

  emp_word_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_en),
    .rd_i   (rd_en),
    .idx_i  (idx),
    .be_i   (be),
    .wdata_i(lanes),
    .rdata_o(word_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q       <= 1'b0;
      err_q      <= 1'b0;
      ok_ld_q    <= 1'b0;
      mode_rsp_q <= 1'b0;
      size_q     <= SZ_BYTE;
      off_q      <= '0;
    end else begin
      ld_q    <= req_i && !we_i;
      err_q   <= req_i && misalign;
      ok_ld_q <= rd_en;
      if (rd_en) begin
        mode_rsp_q <= mode_q;
        size_q     <= size;
        off_q      <= off;
      end
    end
  end

  emp_lane_unpack #(.DATA_W(DATA_W)) i_unpack (
    .size_i(size_q),
    .off_i (off_q),
    .big_i (mode_rsp_q),
    .word_i(word_rd),
    .data_o(ld_val)
  );

  assign rdata_o  = ok_ld_q ? ld_val : '0;
  assign rvalid_o = ld_q;
  assign err_o    = err_q;
endmodule

// File: rtl/emp_checker.sv
module emp_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        size_i,
  input logic [OFF_W-1:0]  off_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic              err_o,
  input logic              mode_q
);
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!rvalid_o && !err_o));

  assert_load_resp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  assert_store_no_resp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> !rvalid_o);

  assert_word_misalign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == 2'd2 && off_i != '0) |=> err_o);

  assert_half_misalign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == 2'd1 && off_i[0]) |=> err_o);

  assert_rsvd_size_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == 2'd3) |=> err_o);

  assert_byte_ok_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == 2'd0) |=> !err_o);

  assert_err_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !req_i) |=> !err_o);

  assert_rdata_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rvalid_o || err_o) |-> (rdata_o == '0));

  assert_byte_zext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == 2'd0) |=> (rdata_o[DATA_W-1:8] == '0));

  assert_half_zext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == 2'd1) |=> (rdata_o[DATA_W-1:16] == '0));

  assert_mode_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> $stable(mode_q));
endmodule

bind endian_mem_port emp_checker #(.DATA_W(DATA_W), .OFF_W(OFF_W)) i_emp_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .size_i  (size_i),
  .off_i   (addr_i[OFF_W-1:0]),
  .rdata_o (rdata_o),
  .rvalid_o(rvalid_o),
  .err_o   (err_o),
  .mode_q  (mode_q)
);

// File: tb/test_endian_mem_port.sv
`timescale 1ns/1ps
module test_endian_mem_port;
  localparam int ADDR_W = 6;
  localparam int NBYTES = 1 << ADDR_W;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        big_endian_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o, err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] ref_mem [NBYTES];
  logic       ref_mode = 1'b0;

  always #2 clk_i = ~clk_i;

  endian_mem_port #(.ADDR_W(ADDR_W), .DATA_W(32)) i_endian_mem_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .big_endian_i(big_endian_i),
    .req_i(req_i), .we_i(we_i), .size_i(size_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .err_o(err_o)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int nbytes_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit bad_align(input logic [1:0] s, input int a);
    case (s)
      2'd0: return 1'b0;
      2'd1: return (a % 2) != 0;
      2'd2: return (a % 4) != 0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] ref_load(input logic [1:0] s, input int a, input logic big);
    logic [31:0] v = '0;
    int n = nbytes_of(s);
    for (int i = 0; i < n; i++) begin
      if (big) v[8*(n-1-i)+:8] = ref_mem[a+i];
      else     v[8*i+:8]       = ref_mem[a+i];
    end
    return v;
  endfunction

  task automatic ref_store(input logic [1:0] s, input int a, input logic big, input logic [31:0] d);
    int n = nbytes_of(s);
    for (int i = 0; i < n; i++) begin
      if (big) ref_mem[a+i] = d[8*(n-1-i)+:8];
      else     ref_mem[a+i] = d[8*i+:8];
    end
  endtask

  // one idle cycle; mode pin captured at its edge
  task automatic idle(input logic mode, input string tag);
    req_i = 1'b0;
    big_endian_i = mode;
    @(negedge clk_i);
    ref_mode = mode;
    check(tag, "idle rvalid", {31'd0, rvalid_o}, 32'd0);
    check(tag, "idle err", {31'd0, err_o}, 32'd0);
    check(tag, "idle rdata", rdata_o, 32'd0);
  endtask

  task automatic access(input logic we, input logic [1:0] s, input int a,
                        input logic [31:0] d, input logic pin_mode, input string tag);
    bit          bad = bad_align(s, a);
    logic [31:0] exp = '0;
    req_i = 1'b1;
    we_i = we;
    size_i = s;
    addr_i = a[ADDR_W-1:0];
    wdata_i = d;
    big_endian_i = pin_mode;
    if (!we && !bad) exp = ref_load(s, a, ref_mode);
    if (we && !bad) ref_store(s, a, ref_mode, d);
    @(negedge clk_i);
    check(tag, "err", {31'd0, err_o}, {31'd0, bad});
    check(tag, "rvalid", {31'd0, rvalid_o}, {31'd0, !we});
    check(tag, "rdata", rdata_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd2024);
    for (int i = 0; i < NBYTES; i++) ref_mem[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    check("R1", "reset rvalid", {31'd0, rvalid_o}, 32'd0);
    check("R1", "reset err", {31'd0, err_o}, 32'd0);
    check("R1", "reset rdata", rdata_o, 32'd0);
    rst_ni = 1'b1;
    idle(1'b0, "R11");
    for (int a = 0; a < NBYTES; a += 4) access(1'b0, 2'd2, a, 32'd0, 1'b0, "R1");

    // little-endian placement
    access(1'b1, 2'd2, 0, 32'h12342A3F, 1'b0, "R2");
    access(1'b0, 2'd0, 0, 32'd0, 1'b0, "R2 R9");
    access(1'b0, 2'd0, 3, 32'd0, 1'b0, "R2");
    access(1'b0, 2'd1, 2, 32'd0, 1'b0, "R7");
    // big-endian placement
    idle(1'b1, "R10");
    access(1'b0, 2'd2, 0, 32'd0, 1'b1, "R2");
    access(1'b1, 2'd2, 4, 32'h12342A3F, 1'b1, "R2");
    access(1'b0, 2'd0, 4, 32'd0, 1'b1, "R2 R7");
    access(1'b0, 2'd1, 6, 32'd0, 1'b1, "R7");
    // narrow stores keep neighbours
    access(1'b1, 2'd0, 5, 32'hFFFF_FFA5, 1'b1, "R8");
    access(1'b1, 2'd1, 2, 32'hFFFF_BEEF, 1'b1, "R8");
    access(1'b0, 2'd2, 4, 32'd0, 1'b1, "R8");
    access(1'b0, 2'd2, 0, 32'd0, 1'b1, "R8");
    // rejected accesses
    access(1'b1, 2'd2, 9, 32'hDEADBEEF, 1'b1, "R4 R5");
    access(1'b1, 2'd1, 7, 32'hDEADBEEF, 1'b1, "R5");
    access(1'b1, 2'd3, 8, 32'hDEADBEEF, 1'b1, "R3");
    idle(1'b1, "R4");
    access(1'b0, 2'd2, 8, 32'd0, 1'b1, "R5");
    access(1'b0, 2'd2, 4, 32'd0, 1'b1, "R5");
    access(1'b0, 2'd2, 2, 32'd0, 1'b1, "R6");
    access(1'b0, 2'd1, 1, 32'd0, 1'b1, "R6");
    access(1'b0, 2'd3, 0, 32'd0, 1'b1, "R3 R6");
    // mode pin moves during back-to-back requests
    idle(1'b0, "R10");
    access(1'b0, 2'd1, 4, 32'd0, 1'b1, "R10");
    access(1'b0, 2'd2, 4, 32'd0, 1'b1, "R10");
    idle(1'b1, "R10");
    access(1'b0, 2'd2, 4, 32'd0, 1'b0, "R10");

    for (int blk = 0; blk < 8; blk++) begin
      idle(blk[0], "R11");
      for (int k = 0; k < 200; k++) begin
        logic        w = $urandom_range(1, 0) == 1;
        logic [1:0]  s = 2'($urandom_range(3, 0));
        int          a = int'($urandom_range(NBYTES - 1, 0));
        logic [31:0] d = $urandom;
        logic        pm = $urandom_range(1, 0) == 1;
        access(w, s, a, d, pm, "R2 R3 R7 R8 R9");
      end
    end
    for (int a = 0; a < NBYTES; a += 4) access(1'b0, 2'd2, a, 32'd0, 1'b0, "R5 R8");
    idle(1'b0, "R11");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule